// File: doc/BRIEF.md
# Register-Controlled SPI Byte Transfer Engine

This block is a single-byte SPI master that software drives through two 8-bit host registers, one holding data and one holding control and status. Software writes the byte to send, then raises a start bit in the control register. The engine copies the data register into its shift register, clears its bit count and sets a load flag. It then clocks eight bits in SPI mode 0, most significant bit first, and sets a done flag when the last bit has gone.

The control register also holds a direction bit and two chip-select bits that software owns and that drive pins directly. On a read access the received byte replaces the data register when the done flag sets. On a write access the data register keeps the byte that was sent. Writing the start bit back to 0 clears both status flags, and it also cancels a transfer that is still running. The serial clock runs at the system clock divided by a parameter.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, and spi_sclk, spi_mosi, tch_cs and cdc_cs are all 0.
- R2: The control register reads back as {0, 0, load, start, done, dir, tch_sel, cdc_sel} from bit 7 down to bit 0. When sel_data is high, rdata shows the data register. When only sel_ctrl is high, it shows the control register. With no select, rdata is 0x00.
- R3: A control write that changes the start bit (bit 4) from 0 to 1 starts a transfer on the next clock. From then on the load flag (bit 5) reads 1.
- R4: During a transfer spi_sclk makes exactly 8 pulses, each lasting CLK_DIV clock cycles: low for the first half and high for the second. spi_sclk is low whenever no transfer is running.
- R5: spi_mosi presents the loaded byte MSB first, one bit per spi_sclk period. It changes only while spi_sclk is low. A device that samples on the rising spi_sclk edges receives the loaded byte.
- R6: The done flag (bit 3) sets one clock after the eighth falling spi_sclk edge, which is 1 + 8*CLK_DIV clocks after the start write. spi_sclk then stays low.
- R7: When the direction bit (bit 2) is 1, the byte sampled from spi_miso on the rising edges replaces the data register as done sets, MSB first. When the direction bit is 0, the data register keeps its value.
- R8: A control write with the start bit at 0 clears the load and done flags on the next clock. If a transfer is running, it ends it: spi_sclk stays low, done does not set, and the data register is left unchanged.
- R9: A control write with the start bit at 1 while start already reads 1 does not start a transfer.
- R10: Writes to the data register are ignored while a transfer is running.
- R11: tch_cs follows control bit 1 and cdc_cs follows control bit 0. The codec select has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_data | input | 1 | Selects the data register |
| sel_ctrl | input | 1 | Selects the control register |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| tch_cs | output | 1 | Touch device select, active high |
| cdc_cs | output | 1 | Codec select, active high |

## Verification
A bit counter that is off by one shows at the pins within one serial period: a ninth or a missing spi_sclk pulse appears, and the done flag comes early or late against the reference timeline. A fault in the shift register or the sampled bit shows on spi_mosi in the affected bit period. For a read it shows again in the data register readback as soon as done sets. A status flag that fails to clear, or a start edge that is missed, shows in the control register readback on the very next cycle, because the reference model is compared against rdata and all four pins on every clock.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
   localparam int REG_W    = 8;
   localparam int CB_LOAD  = 5;
   localparam int CB_START = 4;
   localparam int CB_DONE  = 3;
   localparam int CB_DIR   = 2;
   localparam int CB_TSEL  = 1;
   localparam int CB_CSEL  = 0;
   typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic sclk,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("spi_clk_div: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || restart) begin
         cnt <= '0;
      end else if (cnt == CW'(DIV - 1)) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign sclk      = run && (cnt >= CW'(HALF));
   assign rise_tick = run && (cnt == CW'(HALF - 1));
   assign fall_tick = run && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            abort,
   input  logic [BITS-1:0] load_val,
   input  logic            rise_tick,
   input  logic            fall_tick,
   input  logic            miso,
   output logic            busy,
   output logic            mosi,
   output logic            done_ev,
   output logic [BITS-1:0] rx_byte
);
   localparam int BW   = (BITS > 2) ? $clog2(BITS) : 1;
   localparam int LAST = BITS - 1;

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("spi_byte_shifter: BITS must be at least 2");
      end
   endgenerate

   logic [BITS-1:0] shreg;
   logic [BW-1:0]   bit_cnt;
   logic            rx_bit;
   logic            last_bit;

   assign last_bit = (bit_cnt == BW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg   <= '0;
         bit_cnt <= '0;
         rx_bit  <= 1'b0;
      end else if (abort) begin
         busy <= 1'b0;
      end else if (go) begin
         busy    <= 1'b1;
         shreg   <= load_val;
         bit_cnt <= '0;
         rx_bit  <= 1'b0;
      end else if (busy) begin
         if (rise_tick) begin
            rx_bit <= miso;
         end
         if (fall_tick) begin
            shreg <= {shreg[BITS-2:0], rx_bit};
            if (last_bit) begin
               bit_cnt <= '0;
               busy    <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign mosi    = busy && shreg[BITS-1];
   assign done_ev = busy && fall_tick && last_bit && !abort;
   assign rx_byte = {shreg[BITS-2:0], rx_bit};

   // R6: the final falling edge ends the transfer
   a_r6_last_bit_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fall_tick && last_bit && !abort) |=> !busy);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_xfer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_data,
   input  logic sel_ctrl,
   input  logic wr_en,
   input  reg_t wdata,
   output reg_t rdata,
   input  logic busy,
   input  logic done_ev,
   input  reg_t rx_byte,
   output logic go,
   output logic abort,
   output reg_t data_q,
   output logic done_flag,
   output logic tsel,
   output logic csel
);
   logic start_q, load_q, done_q, dir_q;
   logic ctrl_wr, data_wr;
   reg_t ctrl_view;

   assign ctrl_wr = wr_en && sel_ctrl;
   assign data_wr = wr_en && sel_data;
   assign abort   = ctrl_wr && !wdata[CB_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         dir_q   <= 1'b0;
         tsel    <= 1'b0;
         csel    <= 1'b0;
         go      <= 1'b0;
      end else begin
         go <= ctrl_wr && wdata[CB_START] && !start_q;
         if (ctrl_wr) begin
            start_q <= wdata[CB_START];
            dir_q   <= wdata[CB_DIR];
            tsel    <= wdata[CB_TSEL];
            csel    <= wdata[CB_CSEL];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         done_q <= 1'b0;
      end else if (abort) begin
         load_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (go)      load_q <= 1'b1;
         if (done_ev) done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (done_ev && dir_q) begin
         data_q <= rx_byte;
      end else if (data_wr && !busy) begin
         data_q <= wdata;
      end
   end

   always_comb begin
      ctrl_view           = '0;
      ctrl_view[CB_LOAD]  = load_q;
      ctrl_view[CB_START] = start_q;
      ctrl_view[CB_DONE]  = done_q;
      ctrl_view[CB_DIR]   = dir_q;
      ctrl_view[CB_TSEL]  = tsel;
      ctrl_view[CB_CSEL]  = csel;
   end

   assign rdata     = sel_data ? data_q : (sel_ctrl ? ctrl_view : '0);
   assign done_flag = done_q;

   // R3: the load flag only rises together with an active transfer
   a_r3_load_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_q) |-> busy);
   // R8: writing start low clears both status flags
   a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wdata[CB_START]) |=> (!load_q && !done_q));
   // R9: a start write while start is already set launches nothing
   a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && start_q) |=> !go);
   // R10: data register holds during a transfer
   a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && data_wr && !done_ev) |=> $stable(data_q));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
   import spi_xfer_pkg::*;
#(
   parameter int CLK_DIV = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_data,
   input  logic             sel_ctrl,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             spi_sclk,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic             tch_cs,
   output logic             cdc_cs
);
   logic go, abort, busy, done_ev, done_flag;
   logic rise_tick, fall_tick;
   reg_t data_q, rx_byte;

   spi_host_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_data  (sel_data),
      .sel_ctrl  (sel_ctrl),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .busy      (busy),
      .done_ev   (done_ev),
      .rx_byte   (rx_byte),
      .go        (go),
      .abort     (abort),
      .data_q    (data_q),
      .done_flag (done_flag),
      .tsel      (tch_cs),
      .csel      (cdc_cs)
   );

   spi_clk_div #(.DIV(CLK_DIV)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .restart   (go),
      .sclk      (spi_sclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   spi_byte_shifter #(.BITS(REG_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .abort     (abort),
      .load_val  (data_q),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .miso      (spi_miso),
      .busy      (busy),
      .mosi      (spi_mosi),
      .done_ev   (done_ev),
      .rx_byte   (rx_byte)
   );

   // R5: serial data is steady while the clock is high
   a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
   // R6: once done is set the serial clock is quiet
   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag |-> !spi_sclk);
   // R4: a rising tick drives the serial clock high unless cancelled
   a_r4_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_tick && !abort) |=> spi_sclk);
endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
   localparam int DIV  = 8;
   localparam int HALF = DIV / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_data = 1'b0, sel_ctrl = 1'b0, wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       spi_sclk, spi_mosi, tch_cs, cdc_cs;
   logic       spi_miso = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   spi_xfer_engine #(.CLK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .sel_ctrl(sel_ctrl),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tch_cs(tch_cs), .cdc_cs(cdc_cs)
   );

   // ---------------- serial device model ----------------
   logic [7:0] slv_tx = 8'h00;
   logic       slv_clr = 1'b0;
   logic [7:0] slv_got = 8'h00;
   int         nrise = 0;
   logic       sclk_prev = 1'b0;

   always @(negedge clk) begin
      if (slv_clr) begin
         nrise   = 0;
         slv_got = 8'h00;
      end else if (spi_sclk && !sclk_prev) begin
         slv_got = {slv_got[6:0], spi_mosi};
         nrise   = nrise + 1;
      end
      sclk_prev = spi_sclk;
      spi_miso  = (nrise < 8) ? slv_tx[7 - nrise] : 1'b0;
   end

   // ---------------- reference model ----------------
   logic [7:0] m_data, m_shift, m_rx;
   logic       m_start, m_load, m_done, m_dir, m_tcs, m_ccs, m_active, m_pend;
   int         m_t;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_data = 0; m_shift = 0; m_rx = 0; m_start = 0; m_load = 0; m_done = 0;
         m_dir = 0; m_tcs = 0; m_ccs = 0; m_active = 0; m_pend = 0; m_t = 0;
      end else begin
         logic old_active, old_dir, old_start, kill, launch;
         logic [7:0] old_data;
         old_active = m_active; old_dir = m_dir; old_start = m_start; old_data = m_data;
         kill   = wr_en && sel_ctrl && !wdata[4];
         launch = m_pend;
         m_pend = 0;
         if (old_active && !kill) begin
            if ((m_t % DIV) == HALF - 1) m_rx = {m_rx[6:0], spi_miso};
            if ((m_t % DIV) == DIV - 1 && (m_t / DIV) == 7) begin
               m_active = 0;
               m_done   = 1;
               if (old_dir) m_data = m_rx;
            end
            m_t = m_t + 1;
         end
         if (launch && !kill) begin
            m_active = 1; m_t = 0; m_load = 1; m_shift = old_data; m_rx = 0;
         end
         if (wr_en && sel_data && !old_active) m_data = wdata;
         if (wr_en && sel_ctrl) begin
            if (kill) begin
               m_load = 0; m_done = 0; m_active = 0;
            end
            if (wdata[4] && !old_start) m_pend = 1;
            m_start = wdata[4]; m_dir = wdata[2]; m_tcs = wdata[1]; m_ccs = wdata[0];
         end
      end
   end

   function automatic logic [7:0] exp_rdata();
      if (sel_data) return m_data;
      if (sel_ctrl) return {2'b00, m_load, m_start, m_done, m_dir, m_tcs, m_ccs};
      return 8'h00;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // lockstep compare every clock
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         finish_run();
      end
      if (rst_n) begin
         chk("R4 lockstep sclk", int'(spi_sclk),
             int'(m_active && ((m_t % DIV) >= HALF)));
         chk("R5 lockstep mosi", int'(spi_mosi),
             int'(m_active ? m_shift[7 - (m_t / DIV)] : 1'b0));
         chk("R11 lockstep tch_cs", int'(tch_cs), int'(m_tcs));
         chk("R11 lockstep cdc_cs", int'(cdc_cs), int'(m_ccs));
         chk("R2 lockstep rdata", int'(rdata), int'(exp_rdata()));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input bit to_ctrl, input logic [7:0] v);
      @(posedge clk); #2;
      sel_ctrl = to_ctrl; sel_data = !to_ctrl; wr_en = 1'b1; wdata = v;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic rd(input bit from_ctrl, output logic [7:0] v);
      @(posedge clk); #2;
      sel_ctrl = from_ctrl; sel_data = !from_ctrl; wr_en = 1'b0;
      @(negedge clk);
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic slave_reset(input logic [7:0] tx);
      @(posedge clk); #2;
      slv_tx = tx; slv_clr = 1'b1;
      @(posedge clk); #2;
      slv_clr = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      idle(3); #2;
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b1, v); chk("R1 ctrl after reset", v, 8'h00);
      rd(1'b0, v); chk("R1 data after reset", v, 8'h00);
      chk("R1 pins after reset", {spi_sclk, spi_mosi, tch_cs, cdc_cs}, 4'b0000);

      // write access
      slave_reset(8'h3C);
      wr(1'b0, 8'hA5);
      wr(1'b1, 8'h12);
      rd(1'b1, v); chk("R3 load flag set", v, 8'h32);
      idle(70);
      rd(1'b1, v); chk("R6 done flag set", v, 8'h3A);
      chk("R4 sclk pulse count", nrise, 8);
      chk("R5 byte seen by device", slv_got, 8'hA5);
      rd(1'b0, v); chk("R7 write keeps data", v, 8'hA5);

      // clear flags
      wr(1'b1, 8'h02);
      rd(1'b1, v); chk("R8 flags cleared", v, 8'h02);

      // read access with ignored data write
      slave_reset(8'h96);
      wr(1'b0, 8'h5A);
      wr(1'b1, 8'h16);
      idle(10);
      wr(1'b0, 8'hFF);
      rd(1'b0, v); chk("R10 data write ignored", v, 8'h5A);
      idle(70);
      rd(1'b0, v); chk("R7 read replaces data", v, 8'h96);
      chk("R5 read byte sent", slv_got, 8'h5A);

      // retrigger without a rising start
      slave_reset(8'h00);
      wr(1'b1, 8'h16);
      idle(30);
      chk("R9 no new pulses", nrise, 0);
      rd(1'b1, v); chk("R9 status kept", v, 8'h3E);

      // abort mid transfer
      wr(1'b1, 8'h06);
      slave_reset(8'hF0);
      wr(1'b1, 8'h16);
      idle(20);
      wr(1'b1, 8'h06);
      idle(80);
      rd(1'b1, v); chk("R8 abort no done", v, 8'h06);
      rd(1'b0, v); chk("R8 abort keeps data", v, 8'h96);
      chk("R8 abort stops clock", int'(nrise < 8), 1);

      // codec select only
      wr(1'b1, 8'h01);
      chk("R11 codec pin", {tch_cs, cdc_cs}, 2'b01);
      rd(1'b1, v); chk("R2 ctrl readback", v, 8'h01);
      slave_reset(8'hC3);
      wr(1'b1, 8'h11);
      idle(70);
      chk("R11 touch pin low", int'(tch_cs), 0);
      rd(1'b1, v); chk("R11 transfer done with codec", v, 8'h39);
      rd(1'b0, v); chk("R7 data kept", v, 8'h96);

      @(posedge clk); #2;
      sel_ctrl = 1'b0; sel_data = 1'b0;
      @(negedge clk);
      chk("R2 no select reads zero", rdata, 8'h00);

      idle(2);
      finish_run();
   end
endmodule